// File: doc/BRIEF.md
# I2S Stereo Audio Transmitter

This block turns a stream of stereo sample pairs into a serial audio stream for a DAC codec. It runs entirely in a master-clock domain that runs at 256 times the audio sample rate, for example 12.288 MHz for 48 kHz audio. From that clock it makes the bit clock, the word-select clock and the serial data line. All three come from registers, so none of them can glitch.

A frame lasts 64 bit clocks and holds two 32-bit slots: the left slot first, with the word select low, and then the right slot, with the word select high. Each slot starts with one idle bit. The 24-bit sample follows, most significant bit first, and zeros fill the rest of the slot. Word select and data change only together with a falling edge of the bit clock, so the codec samples them on the rising edge.

Sample pairs enter through a valid/ready port. The block raises `pair_ready` for exactly one master-clock cycle per frame, and that cycle is the one whose closing edge starts the left slot. A pair is taken only when `pair_valid` is high in that cycle. There is no other back-pressure and no queue. A source that is not ready in time simply misses the frame, and the block then sends the previously taken pair again. Both channels of a frame always come from the same pair.

Top module: `i2s_stereo_tx`

## Requirements
- R1: While the synchronous reset `rst` is high, `bclk`, `lrclk`, `sdata` and `pair_ready` are low and the held pair is cleared to zero. The first bit time after reset is bit time 0 of a left slot.
- R2: `bclk` runs at the master clock divided by 4. It is low for 2 master-clock cycles, then high for 2 cycles, starting low after reset.
- R3: `lrclk` has a period of exactly 64 bit clocks. It is low for the 32 bit times of the left slot and high for the 32 bit times of the right slot.
- R4: In the first bit time after every `lrclk` change (slot position 0), `sdata` is 0.
- R5: At slot positions 1 to 24, `sdata` carries sample bits 23 down to 0, most significant first. Positions 25 to 31 are 0.
- R6: `lrclk` and `sdata` change only on the master-clock edge where `bclk` falls.
- R7: `pair_ready` is high for exactly one master-clock cycle per frame: the last cycle of bit time 63, while `lrclk` is high. On the closing edge of that cycle, `lrclk` falls.
- R8: A pair is taken when `pair_valid` and `pair_ready` are both high at a rising master-clock edge. That pair fills the left slot that starts on that edge and the right slot that follows it. If no pair is taken, the frame repeats the last pair taken, or zero after reset.
- R9: `pair_valid` and the sample inputs have no effect in cycles where `pair_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 256 times the sample rate |
| rst | input | 1 | Synchronous reset, active high |
| pair_valid | input | 1 | A sample pair is offered |
| pair_ready | output | 1 | One-cycle acceptance window, once per frame |
| left_sample | input | 24 | Left-channel sample, two's complement |
| right_sample | input | 24 | Right-channel sample, two's complement |
| bclk | output | 1 | Bit clock, master clock divided by 4 |
| lrclk | output | 1 | Word select: 0 for the left slot, 1 for the right slot |
| sdata | output | 1 | Serial data, MSB first, one-bit delay after each word-select change |

## Verification
The assertions assume that reset is held for at least one master-clock edge before the first check. They place no limit on how `pair_valid` behaves, because the block takes a pair only in its own one-cycle window. To keep within this, the stimulus starts every run with a held reset and asserts reset once more in the middle of a frame. It drives inputs only on the falling master-clock edge, and it also raises `pair_valid` with junk data in every cycle except the acceptance window, to show that such offers are ignored.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  // Channel carried by the current slot; the value equals the lrclk level.
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } i2s_chan_e;

  localparam int unsigned DEF_SAMPLE_W = 24;
  localparam int unsigned DEF_SLOT_W   = 32;
  localparam int unsigned DEF_MCLK_DIV = 4;
endpackage

// File: rtl/i2s_bclk_div.sv
module i2s_bclk_div #(
  parameter int unsigned MCLK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic bclk,
  output logic fall_tick
);
  localparam int unsigned CNT_W = (MCLK_DIV > 2) ? $clog2(MCLK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MCLK_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_RISE = CNT_W'(MCLK_DIV / 2 - 1);

  logic [CNT_W-1:0] div_cnt;
  logic             bclk_q;

  // The bit time ends on this edge: bclk falls and the other outputs step.
  assign fall_tick = (div_cnt == CNT_LAST);
  assign bclk      = bclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      bclk_q  <= 1'b0;
    end else begin
      div_cnt <= fall_tick ? '0 : div_cnt + 1'b1;
      if (fall_tick)
        bclk_q <= 1'b0;
      else if (div_cnt == CNT_RISE)
        bclk_q <= 1'b1;
    end
  end

  // R2: both halves of the bit clock last at least two master cycles
  a_r2_high_hold: assert property (@(posedge clk) disable iff (rst)
    $rose(bclk) |=> bclk);
  a_r2_low_hold: assert property (@(posedge clk) disable iff (rst)
    $fell(bclk) |=> !bclk);
  a_r2_fall_on_tick: assert property (@(posedge clk) disable iff (rst)
    fall_tick |=> !bclk);
endmodule

// File: rtl/i2s_frame_seq.sv
module i2s_frame_seq
  import i2s_tx_pkg::*;
#(
  parameter int unsigned SLOT_W = 32
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      fall_tick,
  output logic      lrclk,
  output logic      slot_start,
  output i2s_chan_e next_chan,
  output logic      take_window
);
  localparam int unsigned FRAME_W = 2 * SLOT_W;
  localparam int unsigned BIT_W   = $clog2(FRAME_W);
  localparam int unsigned POS_W   = $clog2(SLOT_W);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

  logic [BIT_W-1:0] bit_cnt;
  logic [BIT_W-1:0] bit_nxt;
  logic             lr_q;

  assign bit_nxt     = bit_cnt + 1'b1;
  assign next_chan   = i2s_chan_e'(bit_nxt[BIT_W-1]);
  assign slot_start  = fall_tick && (bit_nxt[POS_W-1:0] == '0);
  assign take_window = fall_tick && (bit_cnt == BIT_LAST);
  assign lrclk       = lr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      lr_q    <= 1'b0;
    end else if (fall_tick) begin
      bit_cnt <= bit_nxt;
      lr_q    <= bit_nxt[BIT_W-1];
    end
  end

  // R7: the acceptance window is a single cycle wide
  a_r7_window_pulse: assert property (@(posedge clk) disable iff (rst)
    take_window |=> !take_window);
  // R3: word select steps only at the end of a bit time
  a_r3_lr_on_tick: assert property (@(posedge clk) disable iff (rst)
    !$stable(lrclk) |-> $past(fall_tick));
endmodule

// File: rtl/i2s_slot_shifter.sv
module i2s_slot_shifter #(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned SLOT_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fall_tick,
  input  logic                slot_start,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                sdata
);
  localparam int unsigned PAD_W = SLOT_W - SAMPLE_W - 1;

  logic [SLOT_W-1:0] slot_word;
  logic [SLOT_W-1:0] shreg;
  logic              sd_q;

  // The slot image is an idle bit, the sample MSB first, then zero fill.
  generate
    if (PAD_W > 0) begin : g_pad
      assign slot_word = {1'b0, sample, {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign slot_word = {1'b0, sample};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      sd_q  <= 1'b0;
    end else if (slot_start) begin
      shreg <= slot_word;
      sd_q  <= slot_word[SLOT_W-1];
    end else if (fall_tick) begin
      shreg <= shreg << 1;
      sd_q  <= shreg[SLOT_W-2];
    end
  end

  assign sdata = sd_q;

  // R4: the bit time that opens a slot never carries data
  a_r4_idle_first: assert property (@(posedge clk) disable iff (rst)
    $past(slot_start) |-> !sdata);
  // R6: data moves only at the end of a bit time
  a_r6_sd_on_tick: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata) |-> $past(fall_tick));
endmodule

// File: rtl/i2s_stereo_tx.sv
module i2s_stereo_tx
  import i2s_tx_pkg::*;
#(
  parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
  parameter int unsigned SLOT_W   = DEF_SLOT_W,
  parameter int unsigned MCLK_DIV = DEF_MCLK_DIV
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pair_valid,
  output logic                pair_ready,
  input  logic [SAMPLE_W-1:0] left_sample,
  input  logic [SAMPLE_W-1:0] right_sample,
  output logic                bclk,
  output logic                lrclk,
  output logic                sdata
);
  logic                fall_tick;
  logic                slot_start;
  logic                take_window;
  i2s_chan_e           next_chan;
  logic                accept;
  logic [SAMPLE_W-1:0] held_left;
  logic [SAMPLE_W-1:0] held_right;
  logic [SAMPLE_W-1:0] left_src;
  logic [SAMPLE_W-1:0] slot_sample;

  i2s_bclk_div #(.MCLK_DIV(MCLK_DIV)) u_div (
    .clk       (clk),
    .rst       (rst),
    .bclk      (bclk),
    .fall_tick (fall_tick)
  );

  i2s_frame_seq #(.SLOT_W(SLOT_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .fall_tick   (fall_tick),
    .lrclk       (lrclk),
    .slot_start  (slot_start),
    .next_chan   (next_chan),
    .take_window (take_window)
  );

  assign pair_ready = take_window;
  assign accept     = pair_valid && take_window;
  assign left_src   = accept ? left_sample : held_left;
  assign slot_sample = (next_chan == CH_RIGHT) ? held_right : left_src;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_left  <= '0;
      held_right <= '0;
    end else if (accept) begin
      held_left  <= left_sample;
      held_right <= right_sample;
    end
  end

  i2s_slot_shifter #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .fall_tick  (fall_tick),
    .slot_start (slot_start),
    .sample     (slot_sample),
    .sdata      (sdata)
  );

  // R3: word select moves with a falling bit clock
  a_r3_lr_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(lrclk) |-> $fell(bclk));
  // R6: data moves with a falling bit clock
  a_r6_sd_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata) |-> $fell(bclk));
  // R7: window sits at the end of the right slot and opens the left one
  a_r7_ready_in_right: assert property (@(posedge clk) disable iff (rst)
    pair_ready |-> (lrclk && bclk));
  a_r7_left_follows: assert property (@(posedge clk) disable iff (rst)
    pair_ready |=> !lrclk);
  // R4: a word-select change always comes with an idle data bit
  a_r4_gap_on_change: assert property (@(posedge clk) disable iff (rst)
    !$stable(lrclk) |-> !sdata);
endmodule

// File: tb/i2s_stereo_tx_tb_top.sv
module i2s_stereo_tx_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pair_valid = 1'b0;
  logic        pair_ready;
  logic [23:0] left_sample = '0;
  logic [23:0] right_sample = '0;
  logic        bclk, lrclk, sdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // reference model state
  int          k = 0;
  logic [23:0] m_left = '0;
  logic [23:0] m_right = '0;
  bit          started = 0;
  logic        prev_sd = 1'b0;
  logic        prev_bclk = 1'b0;
  logic        prev_lr = 1'b0;
  string       phase_tag = "R5";

  i2s_stereo_tx dut_i (
    .clk          (clk),
    .rst          (rst),
    .pair_valid   (pair_valid),
    .pair_ready   (pair_ready),
    .left_sample  (left_sample),
    .right_sample (right_sample),
    .bclk         (bclk),
    .lrclk        (lrclk),
    .sdata        (sdata)
  );

  always #10 clk = ~clk;

  function automatic bit win_now(int kk);
    return (kk % 4 == 3) && (((kk / 4) % 64) == 63);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at k=%0d: actual %0d expected %0d", req, what, k, act, exp);
    end
  endtask

  // model advances on every rising edge (R8: pair taken in the window)
  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      k = 0; m_left = '0; m_right = '0;
    end else begin
      if (pair_valid && win_now(k)) begin
        m_left = left_sample; m_right = right_sample;
      end
      k = k + 1;
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      int b, p, eb;
      logic [23:0] s;
      logic e_bclk, e_lr, e_sd, e_rdy;
      b = (k / 4) % 64;
      p = b % 32;
      s = (b < 32) ? m_left : m_right;
      e_bclk = (k % 4) >= 2;
      e_lr   = (b >= 32);
      e_sd   = (p >= 1 && p <= 24) ? s[24 - p] : 1'b0;
      e_rdy  = win_now(k);
      if (rst) begin
        check(!bclk && !lrclk && !sdata && !pair_ready, "R1", "reset state",
              {bclk, lrclk, sdata, pair_ready}, 0);
      end else begin
        check(bclk == e_bclk, "R2", "bclk", bclk, e_bclk);
        check(lrclk == e_lr, "R3", "lrclk", lrclk, e_lr);
        if (p == 0)
          check(sdata == e_sd, "R4", "idle bit", sdata, e_sd);
        else
          check(sdata == e_sd, phase_tag, "sdata", sdata, e_sd);
        check(pair_ready == e_rdy, "R7", "pair_ready", pair_ready, e_rdy);
        if (sdata != prev_sd || lrclk != prev_lr) begin
          eb = (prev_bclk && !bclk) ? 1 : 0;
          check(eb == 1, "R6", "change without bclk fall", eb, 1);
        end
      end
      prev_sd = sdata; prev_bclk = bclk; prev_lr = lrclk;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // offer a pair and hold it until the window closes on it
  task automatic send_pair(logic [23:0] l, logic [23:0] r);
    @(negedge clk);
    pair_valid = 1'b1; left_sample = l; right_sample = r;
    forever begin
      @(negedge clk);
      if (win_now(k)) break;
    end
    @(negedge clk);
    pair_valid = 1'b0; left_sample = 24'h0BAD00; right_sample = 24'h00BAD0;
  endtask

  // R9: junk offers in every cycle outside the window
  task automatic junk(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (win_now(k)) pair_valid = 1'b0;
      else begin
        pair_valid = 1'b1;
        left_sample = 24'(i * 37 + 5);
        right_sample = 24'(~(i * 91));
      end
    end
    @(negedge clk);
    pair_valid = 1'b0;
  endtask

  initial begin
    idle(5);                       // R1 reset held
    rst = 1'b0;
    phase_tag = "R8";              // no pair yet: zeros resent
    idle(300);
    send_pair(24'hA5A5A5, 24'h5A5A5A);
    phase_tag = "R9";
    junk(600);                     // previous pair must persist
    phase_tag = "R5";
    send_pair(24'hFFFFFF, 24'h000001);
    send_pair(24'h800000, 24'h7FFFFF);
    send_pair(24'h000000, 24'hFFFFFF);
    send_pair(24'h123456, 24'hABCDEF);
    phase_tag = "R8";
    idle(520);                     // repeat last pair
    idle(77);
    rst = 1'b1;                    // mid-frame reset, R1
    idle(3);
    rst = 1'b0;
    phase_tag = "R5";
    send_pair(24'hC3C3C3, 24'h3C3C3C);
    idle(300);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule